// File: doc/BRIEF.md
# Timestamped Token Channel FIFO

This block is the channel between two simulated processor nodes in a dataflow performance simulator. It stores no payload. Each entry is the simulation time at which the producer made a token. The consumer reads a channel-time output to decide whether it is safe to act. While tokens are queued, that output is the time of the oldest one. Once the channel drains, the output is the time of the most recent token received.

Besides ordinary data tokens, the producer may send a control token. A control token is a promise that no data will arrive before a given time. It occupies no entry. It only raises the time that an empty channel reports, so a waiting consumer can move forward without deadlocking.

The consumer removes a whole firing's worth of tokens (its rate) in one cycle. The request is granted only when that many tokens are present. On a grant, the time of the last token in the removed group is returned as the channel's contribution to the consumer's ready time. A producer that writes a time lower than its previous write is flagged.

Top module: `tsfifo_top`

## Requirements
- R1: While at least one token is stored, `chanTime` equals the timestamp of the oldest stored token.
- R2: While no token is stored, `chanTime` equals the timestamp of the most recent accepted data write. A control token can raise it (R3). After reset it is 0.
- R3: A control token accepted while the channel is empty sets the empty-channel time to the larger of its current value and the control time. `count` does not change.
- R4: A control token is ignored when the channel holds tokens, or when a data write is accepted in the same cycle. `chanTime` and `count` are then exactly as the data path alone makes them.
- R5: `monoErr` is high for exactly the one cycle after an accepted data write whose timestamp is lower than the previous accepted data write's timestamp. The previous write's timestamp counts as 0 after reset. The offending token is still stored.
- R6: `full` is high when `count` equals DEPTH (default 8). `empty` is high when `count` is 0. A data write made while `full` is high is dropped and leaves `count` and `chanTime` unchanged.
- R7: `rdAccept` is high in the same cycle as the request exactly when `rdReq` is high and 1 <= `rdRate` <= `count`. An accepted read removes the `rdRate` oldest tokens at the clock edge.
- R8: One cycle after an accepted read, `rdLastTime` holds the timestamp of the last (newest) token of the removed group. Otherwise `rdLastTime` keeps its value. It is 0 after reset.
- R9: A read request that is not accepted (rate 0, or rate above `count`) removes nothing. `count` and `chanTime` stay unchanged.
- R10: An accepted read and an accepted write in the same cycle both take effect. `count` changes by +1 minus the rate. Write acceptance uses the `full` state from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Data token write request |
| wrTime | input | TS_W | Timestamp of the data token |
| ctlValid | input | 1 | Control token write request |
| ctlTime | input | TS_W | Lower bound promised by the control token |
| rdReq | input | 1 | Consumer read request |
| rdRate | input | CNT_W | Number of tokens to remove |
| rdAccept | output | 1 | Read granted this cycle |
| rdLastTime | output | TS_W | Timestamp of the last token of the most recent granted read |
| chanTime | output | TS_W | Channel time: head timestamp, or empty-channel time |
| full | output | 1 | All DEPTH entries occupied |
| empty | output | 1 | No entries occupied |
| count | output | CNT_W | Number of stored tokens |
| monoErr | output | 1 | One-cycle pulse after a decreasing data write |

## Verification
A corrupted read or write pointer would show up on `chanTime` at the first cycle after the faulty update. It would also appear as a wrong group-end time on `rdLastTime` one cycle after the next granted read. A drifted occupancy counter is visible at once on `count`, `full` and `empty`. It also changes which multi-token reads `rdAccept` grants, in the same cycle as the request. A stale empty-channel register stays hidden while tokens are queued. It surfaces at the first cycle the channel drains, which is why every drain and every control token is followed by a `chanTime` comparison against the queue model.

// File: rtl/tsfifo_pkg.sv
package tsfifo_pkg;

  // Strobes from control to datapath, one set per cycle.
  typedef struct packed {
    logic wrEn;   // data token stored at the tail
    logic ctlEn;  // control token applied to the empty-channel time
    logic rdEn;   // group of tokens removed from the head
  } chanStrobe_t;

endpackage

// File: rtl/tsfifo_ctrl.sv
module tsfifo_ctrl
  import tsfifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic             ctlValid,
  input  logic             rdReq,
  input  logic [CNT_W-1:0] rdRate,
  output chanStrobe_t      strobe,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             rdAccept
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] countNext;

  assign full  = (count == DEPTH_C);
  assign empty = (count == '0);

  always_comb begin
    strobe.rdEn  = rdReq && (rdRate != '0) && (rdRate <= count);
    strobe.wrEn  = wrValid && !full;
    strobe.ctlEn = ctlValid && empty && !strobe.wrEn;
  end

  assign rdAccept = strobe.rdEn;

  always_comb begin
    countNext = count;
    if (strobe.rdEn) countNext = countNext - rdRate;
    if (strobe.wrEn) countNext = countNext + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else       count <= countNext;
  end

  // R6: occupancy never exceeds the configured depth
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= DEPTH_C);

  // R10: count steps by the writes minus the granted rate
  a_r10_count_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn && strobe.wrEn |=> count == $past(count) - $past(rdRate) + CNT_W'(1));

  // R9: an ungranted read with no write leaves the occupancy alone
  a_r9_no_consume: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn && !strobe.wrEn |=> $stable(count));

endmodule

// File: rtl/tsfifo_dpath.sv
module tsfifo_dpath
  import tsfifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TS_W  = 32,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanStrobe_t      strobe,
  input  logic [CNT_W-1:0] rdRate,
  input  logic [TS_W-1:0]  wrTime,
  input  logic [TS_W-1:0]  ctlTime,
  input  logic             empty,
  output logic [TS_W-1:0]  chanTime,
  output logic [TS_W-1:0]  rdLastTime,
  output logic             monoErr
);

  logic [TS_W-1:0]  slotTime [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] groupEnd;
  logic [TS_W-1:0]  floorTime;
  logic [TS_W-1:0]  prevWrTime;

  // Per-slot storage; one enable per entry.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.wrEn && (wrPtr == PTR_W'(i))) slotTime[i] <= wrTime;
    end
  end

  // Index of the newest token in the group being removed (modulo depth).
  assign groupEnd = rdPtr + rdRate[PTR_W-1:0] - PTR_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.wrEn) wrPtr <= wrPtr + PTR_W'(1);
      if (strobe.rdEn) rdPtr <= rdPtr + rdRate[PTR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdLastTime <= '0;
    else if (strobe.rdEn) rdLastTime <= slotTime[groupEnd];
  end

  // Empty-channel time: last data token received, raised by control tokens.
  always_ff @(posedge clk) begin
    if (!rstN) floorTime <= '0;
    else if (strobe.wrEn) floorTime <= wrTime;
    else if (strobe.ctlEn && (ctlTime > floorTime)) floorTime <= ctlTime;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevWrTime <= '0;
      monoErr    <= 1'b0;
    end else begin
      monoErr <= strobe.wrEn && (wrTime < prevWrTime);
      if (strobe.wrEn) prevWrTime <= wrTime;
    end
  end

  assign chanTime = empty ? floorTime : slotTime[rdPtr];

  // R1: the head time cannot change while tokens are held and none are removed
  a_r1_head_hold: assert property (@(posedge clk) disable iff (!rstN)
    !empty && !strobe.rdEn |=> chanTime == $past(chanTime));

  // R2: an idle empty channel keeps reporting the same time
  a_r2_empty_hold: assert property (@(posedge clk) disable iff (!rstN)
    empty && !strobe.wrEn && !strobe.ctlEn && !strobe.rdEn |=> $stable(chanTime));

  // R3: after a control token the channel time is at least the promise
  a_r3_ctl_raise: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ctlEn |=> chanTime >= $past(ctlTime) && chanTime >= $past(chanTime));

  // R5: the error pulse only follows a stored data write
  a_r5_flag_after_write: assert property (@(posedge clk) disable iff (!rstN)
    monoErr |-> $past(strobe.wrEn));

  // R8: the group-end time holds when nothing is read
  a_r8_last_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> $stable(rdLastTime));

endmodule

// File: rtl/tsfifo_top.sv
module tsfifo_top
  import tsfifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TS_W  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [TS_W-1:0]  wrTime,
  input  logic             ctlValid,
  input  logic [TS_W-1:0]  ctlTime,
  input  logic             rdReq,
  input  logic [CNT_W-1:0] rdRate,
  output logic             rdAccept,
  output logic [TS_W-1:0]  rdLastTime,
  output logic [TS_W-1:0]  chanTime,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] count,
  output logic             monoErr
);

  chanStrobe_t strobe;

  tsfifo_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrValid  (wrValid),
    .ctlValid (ctlValid),
    .rdReq    (rdReq),
    .rdRate   (rdRate),
    .strobe   (strobe),
    .count    (count),
    .full     (full),
    .empty    (empty),
    .rdAccept (rdAccept)
  );

  tsfifo_dpath #(.DEPTH(DEPTH), .TS_W(TS_W), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rdRate     (rdRate),
    .wrTime     (wrTime),
    .ctlTime    (ctlTime),
    .empty      (empty),
    .chanTime   (chanTime),
    .rdLastTime (rdLastTime),
    .monoErr    (monoErr)
  );

endmodule

// File: tb/tsfifo_top_tb.sv
module tsfifo_top_tb;

  localparam int DEPTH = 8;
  localparam int TS_W  = 32;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrValid = 1'b0;
  logic [TS_W-1:0]  wrTime = '0;
  logic             ctlValid = 1'b0;
  logic [TS_W-1:0]  ctlTime = '0;
  logic             rdReq = 1'b0;
  logic [CNT_W-1:0] rdRate = '0;
  logic             rdAccept;
  logic [TS_W-1:0]  rdLastTime;
  logic [TS_W-1:0]  chanTime;
  logic             full;
  logic             empty;
  logic [CNT_W-1:0] count;
  logic             monoErr;

  int nChecks = 0;
  int nFails  = 0;

  // Scoreboard model
  logic [31:0] modelQ[$];
  logic [31:0] rdExpQ[$];
  logic [31:0] floorT = 0;
  logic [31:0] lastIn = 0;

  always #2 clk = ~clk;

  tsfifo_top #(.DEPTH(DEPTH), .TS_W(TS_W)) u_dut (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrTime(wrTime),
    .ctlValid(ctlValid), .ctlTime(ctlTime),
    .rdReq(rdReq), .rdRate(rdRate),
    .rdAccept(rdAccept), .rdLastTime(rdLastTime),
    .chanTime(chanTime), .full(full), .empty(empty),
    .count(count), .monoErr(monoErr)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Monitor: pops the expected group-end time one cycle after a grant (R8).
  always @(negedge clk) begin
    if (rdExpQ.size() > 0) begin
      logic [31:0] e;
      e = rdExpQ.pop_front();
      chk("R8 rdLastTime", rdLastTime, e);
    end
  end

  // Driver: one cycle of stimulus, entered and left at a falling edge.
  task automatic step(bit w, int wt, bit c, int ct, bit r, int rate);
    bit wrOk, rdOk, ctlOk, expMono;
    int szB;
    logic [31:0] lastPop;
    wrValid = w; wrTime = wt; ctlValid = c; ctlTime = ct;
    rdReq = r; rdRate = CNT_W'(rate);
    #1;
    szB   = modelQ.size();
    rdOk  = r && rate >= 1 && rate <= szB;
    wrOk  = w && szB < DEPTH;
    ctlOk = c && szB == 0 && !wrOk;
    chk("R7 rdAccept", {31'd0, rdAccept}, {31'd0, rdOk});
    lastPop = 0;
    if (rdOk) begin
      for (int i = 0; i < rate; i++) lastPop = modelQ.pop_front();
      rdExpQ.push_back(lastPop);
    end
    expMono = 0;
    if (wrOk) begin
      expMono = (wt < lastIn);
      lastIn = wt;
      floorT = wt;
      modelQ.push_back(wt);
    end
    if (ctlOk && ct > floorT) floorT = ct;
    @(negedge clk);
    wrValid = 0; ctlValid = 0; rdReq = 0; rdRate = '0;
    chk("R6 R9 R10 count", 32'(count), 32'(modelQ.size()));
    chk("R6 empty", {31'd0, empty}, {31'd0, modelQ.size() == 0});
    chk("R6 full", {31'd0, full}, {31'd0, modelQ.size() == DEPTH});
    if (modelQ.size() > 0) chk("R1 chanTime head", chanTime, modelQ[0]);
    else                   chk("R2 R3 R4 chanTime empty", chanTime, floorT);
    chk("R5 monoErr", {31'd0, monoErr}, {31'd0, expMono});
  endtask

  initial begin
    #(4 * 100000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    int tNow;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // Reset state (R2, R6, R8, R5)
    chk("R2 reset chanTime", chanTime, 0);
    chk("R6 reset empty", {31'd0, empty}, 1);
    chk("R6 reset count", 32'(count), 0);
    chk("R8 reset rdLastTime", rdLastTime, 0);
    chk("R5 reset monoErr", {31'd0, monoErr}, 0);

    // R3: control tokens on an empty channel, max rule
    step(0, 0, 1, 50, 0, 0);
    step(0, 0, 1, 30, 0, 0);
    // R1: data tokens, head time
    step(1, 10, 0, 0, 0, 0);
    step(1, 20, 0, 0, 0, 0);
    step(1, 20, 0, 0, 0, 0);
    step(1, 35, 0, 0, 0, 0);
    // R4: control while holding tokens
    step(0, 0, 1, 100, 0, 0);
    // R9: rate above count, then rate 0
    step(0, 0, 0, 0, 1, 5);
    step(0, 0, 0, 0, 1, 0);
    // R7 R8: grouped read of two
    step(0, 0, 0, 0, 1, 2);
    // R5: decreasing write flagged and stored
    step(1, 15, 0, 0, 0, 0);
    step(1, 40, 0, 0, 0, 0);
    // R6: fill to full, then a dropped write
    for (int i = 0; i < DEPTH; i++) step(1, 50 + i, 0, 0, 0, 0);
    step(1, 3, 0, 0, 0, 0);
    // R10: read and write together while full
    step(1, 70, 0, 0, 1, 3);
    step(1, 71, 0, 0, 1, 1);
    // R2: drain completely, empty time is the last write
    step(0, 0, 0, 0, 1, DEPTH);
    step(0, 0, 0, 0, 1, modelQ.size());
    // R4: control and write in the same empty cycle
    step(1, 80, 1, 200, 0, 0);
    step(0, 0, 0, 0, 1, 1);
    step(0, 0, 1, 90, 0, 0);

    // Mixed traffic from an LFSR
    lfsr = 32'h1ACE_B00C;
    tNow = 100;
    for (int n = 0; n < 400; n++) begin
      bit w, c, r;
      int rate, wt;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      w = lfsr[0] | lfsr[5];
      c = lfsr[1];
      r = lfsr[2] & lfsr[7];
      rate = int'(lfsr[11:8]) % (DEPTH + 1);
      tNow += int'(lfsr[14:12]);
      wt = (lfsr[20:15] == 6'd0) ? tNow - 5 : tNow;
      step(w, wt, c, tNow + int'(lfsr[24:22]), r, rate);
    end

    step(0, 0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule